// File: doc/BRIEF.md
# Debug Breakpoint and Run Control Unit

This unit sits beside a small 8-bit microcontroller core and gives a host debugger control over execution. It watches every memory access the CPU makes. Each access is tagged with one of four address spaces: code, internal data, external data and the special-register space. A set of hardware breakpoint comparators checks each access. A breakpoint can fire on a read, on a write or on both, and it can also require that the data bits selected by a mask equal a pattern. When a breakpoint fires while the CPU is running, the unit stops the CPU at the next instruction boundary. An instruction that is already under way finishes first.

The host talks to the unit through a plain command and configuration port. Four commands are available: halt, resume, single-step, and skip, which moves the program counter past one instruction without executing it. Each comparator has a sticky hit flag that the host clears by writing a one to it. Two status outputs report the unit's state. One shows whether the CPU is free to run. The other shows whether a debugger memory access is in progress. When the debug enable is low, the unit goes quiet: the comparators are gated off, the flags are held clear, and the CPU runs freely.

The CPU side uses three signals. The CPU drives `cpu_busy` high during every cycle of an instruction, and pulses `instr_done` on the last of those cycles. It starts a new instruction only from an idle cycle in which `exec_en` is high.

Top module: `dbg_brk_ctl`

## Requirements
- R1: A breakpoint fires only on an access that meets all of these conditions: the breakpoint's enable is set, the access space equals its space field, and the access address equals its address field. Its read enable must be set for a read, or its write enable for a write. A breakpoint with both direction enables clear never fires. Config word layout, from bit 0 upward: mask[7:0], pattern[15:8], address[31:16], space[33:32] (0 code, 1 internal data, 2 external data, 3 special register), write enable bit 34, read enable bit 35, enable bit 36.
- R2: A breakpoint with a nonzero mask fires only when (data XOR pattern) AND mask is zero. A mask bit of 0 makes that data bit a don't-care, so a zero mask means no data condition.
- R3: A firing breakpoint sets its bit in `hit_flags` one cycle later. The bit stays set until the host writes a one to it through `flag_clr`. If a set and a clear reach the same bit in the same cycle, the set wins.
- R4: A breakpoint hit or a halt command (code 1) in the running state drops `exec_en` on the next cycle. `halted` rises once the CPU has finished its current instruction. That instruction completes, and no further instruction starts.
- R5: A run command (code 2) issued while halted raises `exec_en` on the next cycle, and instructions execute again.
- R6: A step command (code 3) issued while halted lets exactly one instruction execute. The unit is halted again in the cycle after that instruction's `instr_done`.
- R7: A skip command (code 4) issued while halted raises `skip_req` for exactly one cycle. `exec_en` stays low throughout, no instruction executes, and the unit is then halted again.
- R8: `code_run` is high whenever the unit is neither halted nor skipping, and low in both of those states.
- R9: `dbg_acc` is high in the cycle after a `host_mem_req` cycle in which the unit was halted. A request made while the CPU is not halted is ignored.
- R10: While `dbg_en` is low, the unit is in the running state, `hit_flags` is cleared, no breakpoint fires and every command is ignored.
- R11: After reset, the unit is running, with `exec_en` and `code_run` high and `halted`, `skip_req`, `dbg_acc` and `hit_flags` low. All breakpoints are unconfigured.
- R12: A command that does not apply to the present state is ignored. Halt is ignored while halted. Step, skip and run are ignored while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug unit enable; low puts the unit in its quiet state |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Command code: 1 halt, 2 run, 3 step, 4 skip |
| cfg_we | input | 1 | Breakpoint configuration write strobe |
| cfg_idx | input | IDX_W (2) | Breakpoint selected for configuration |
| cfg_wdata | input | CFG_W (37) | Breakpoint configuration word (layout in R1) |
| flag_clr_we | input | 1 | Hit flag clear strobe |
| flag_clr | input | NUM_BP (4) | Write-one-to-clear mask for hit flags |
| hit_flags | output | NUM_BP (4) | Sticky per-breakpoint hit flags |
| host_mem_req | input | 1 | Host requests a debugger memory access |
| acc_valid | input | 1 | CPU memory access valid |
| acc_write | input | 1 | CPU access is a write (0 is a read) |
| acc_space | input | 2 | Address space of the CPU access |
| acc_addr | input | ADDR_W (16) | CPU access address |
| acc_data | input | DATA_W (8) | CPU access data |
| cpu_busy | input | 1 | CPU is inside an instruction |
| instr_done | input | 1 | Last cycle of the current instruction |
| exec_en | output | 1 | CPU may start an instruction |
| skip_req | output | 1 | Advance the program counter past one instruction |
| halted | output | 1 | Unit is in the halted state |
| code_run | output | 1 | CPU is free to run (not halted, not skipping) |
| dbg_acc | output | 1 | Debugger access in progress |

## Verification
The assertions check several behaviours on every cycle. A comparator hit always sets its flag on the next cycle. A clear without a competing hit always empties the flag. A hit while running always drops `exec_en`. The unit never reports halted while an instruction is still in progress. A step always returns to halted after its `instr_done`. A skip lasts one cycle. The unit is quiet whenever it is disabled. Other properties depend on the CPU's handshake and on the order of commands, so only the bench's scenarios can show them. Those scenarios confirm that a step runs exactly one instruction and that a skip runs none. They confirm that the instruction in progress at a halt completes, and that commands arriving in the wrong state leave the unit unchanged. A behavioural model in the bench follows the comparators and the run state every cycle, and it is compared with the outputs on each clock.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

  typedef enum logic [2:0] {
    RC_RUN       = 3'd0,
    RC_HALT_PEND = 3'd1,
    RC_HALTED    = 3'd2,
    RC_STEP      = 3'd3,
    RC_SKIP      = 3'd4
  } rc_state_e;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_HALT = 3'd1,
    CMD_RUN  = 3'd2,
    CMD_STEP = 3'd3,
    CMD_SKIP = 3'd4
  } host_cmd_e;

  localparam int SPACE_W = 2;

endpackage

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit #(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 8,
  localparam int CFG_W  = ADDR_W + 2 * DATA_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  output logic              hit
);

  // field positions inside the configuration word
  localparam int PAT_LO = DATA_W;
  localparam int ADR_LO = 2 * DATA_W;
  localparam int SPC_LO = ADR_LO + ADDR_W;
  localparam int WR_B   = SPC_LO + 2;
  localparam int RD_B   = WR_B + 1;
  localparam int EN_B   = RD_B + 1;

  logic [CFG_W-1:0] cfg_q;
  logic             dir_ok, addr_ok, space_ok, data_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
    end
  end

  always_comb begin
    dir_ok   = acc_write ? cfg_q[WR_B] : cfg_q[RD_B];
    addr_ok  = (acc_addr == cfg_q[SPC_LO-1:ADR_LO]);
    space_ok = (acc_space == cfg_q[WR_B-1:SPC_LO]);
    data_ok  = ((acc_data ^ cfg_q[ADR_LO-1:PAT_LO]) & cfg_q[PAT_LO-1:0]) == '0;
    // comparator output is gated off entirely while the unit is inactive
    hit      = active & acc_valid & cfg_q[EN_B] & dir_ok & addr_ok & space_ok & data_ok;
  end

  // R1: a hit is only ever reported for a live CPU access while active
  a_r1_hit_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (acc_valid && active));

endmodule

// File: rtl/dbg_run_ctl.sv
module dbg_run_ctl
  import dbg_brk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbg_en,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       bp_hit_any,
  input  logic       cpu_busy,
  input  logic       instr_done,
  input  logic       host_mem_req,
  output logic       exec_en,
  output logic       skip_req,
  output logic       halted,
  output logic       code_run,
  output logic       dbg_acc
);

  rc_state_e state_q, state_d;
  host_cmd_e op;
  logic      dacc_d, dacc_q;
  logic      boundary;

  assign op       = host_cmd_e'(cmd_op);
  assign boundary = instr_done | ~cpu_busy;

  always_comb begin
    state_d = state_q;
    if (!dbg_en) begin
      state_d = RC_RUN;
    end else begin
      case (state_q)
        RC_RUN:       if (bp_hit_any || (cmd_valid && op == CMD_HALT)) state_d = RC_HALT_PEND;
        RC_HALT_PEND: if (boundary) state_d = RC_HALTED;
        RC_HALTED: begin
          if (cmd_valid) begin
            case (op)
              CMD_RUN:  state_d = RC_RUN;
              CMD_STEP: state_d = RC_STEP;
              CMD_SKIP: state_d = RC_SKIP;
              default:  state_d = RC_HALTED;
            endcase
          end
        end
        RC_STEP:      if (instr_done) state_d = RC_HALTED;
        RC_SKIP:      state_d = RC_HALTED;
        default:      state_d = RC_HALTED;
      endcase
    end
    dacc_d = dbg_en & host_mem_req & (state_q == RC_HALTED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RC_RUN;
      dacc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dacc_q  <= dacc_d;
    end
  end

  assign exec_en  = (state_q == RC_RUN) || (state_q == RC_STEP);
  assign skip_req = (state_q == RC_SKIP);
  assign halted   = (state_q == RC_HALTED);
  assign code_run = !((state_q == RC_HALTED) || (state_q == RC_SKIP));
  assign dbg_acc  = dacc_q;

  // R4: a hit while running withdraws execute permission on the next cycle
  a_r4_hold_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_en && state_q == RC_RUN && bp_hit_any) |=> !exec_en);

  // R4: halted is never reported while an instruction is still in flight
  a_r4_pend_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_en && state_q == RC_HALT_PEND && cpu_busy && !instr_done) |=> !halted);

  // R6: a step returns to halted right after its completing instruction
  a_r6_step_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_en && state_q == RC_STEP && instr_done) |=> halted);

  // R7: a skip request lasts a single cycle and lands in halted
  a_r7_skip_single: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_req && dbg_en) |=> (halted && !skip_req));

endmodule

// File: rtl/dbg_brk_ctl.sv
module dbg_brk_ctl
  import dbg_brk_pkg::*;
#(
  parameter  int NUM_BP = 4,
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 8,
  localparam int IDX_W  = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int CFG_W  = ADDR_W + 2 * DATA_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              flag_clr_we,
  input  logic [NUM_BP-1:0] flag_clr,
  output logic [NUM_BP-1:0] hit_flags,
  input  logic              host_mem_req,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              cpu_busy,
  input  logic              instr_done,
  output logic              exec_en,
  output logic              skip_req,
  output logic              halted,
  output logic              code_run,
  output logic              dbg_acc
);

  logic [NUM_BP-1:0] hit_vec;
  logic [NUM_BP-1:0] flags_q, flags_d;
  logic              flags_ce;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    dbg_bp_unit #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_bp (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (dbg_en),
      .cfg_we    (cfg_we && (cfg_idx == IDX_W'(g))),
      .cfg_wdata (cfg_wdata),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_space (acc_space),
      .acc_addr  (acc_addr),
      .acc_data  (acc_data),
      .hit       (hit_vec[g])
    );

    // R3: a comparator hit always leaves its sticky flag set
    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[g] |=> hit_flags[g]);

    // R3: an uncontested write-one-to-clear empties the flag
    a_r3_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_en && flag_clr_we && flag_clr[g] && !hit_vec[g]) |=> !hit_flags[g]);
  end

  // flag register only clocks when something can change it
  always_comb begin
    flags_ce = !dbg_en || flag_clr_we || (|hit_vec);
    if (!dbg_en) begin
      flags_d = '0;
    end else begin
      flags_d = (flags_q & ~(flag_clr_we ? flag_clr : '0)) | hit_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_ce) begin
      flags_q <= flags_d;
    end
  end

  assign hit_flags = flags_q;

  dbg_run_ctl u_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_en       (dbg_en),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .bp_hit_any   (|hit_vec),
    .cpu_busy     (cpu_busy),
    .instr_done   (instr_done),
    .host_mem_req (host_mem_req),
    .exec_en      (exec_en),
    .skip_req     (skip_req),
    .halted       (halted),
    .code_run     (code_run),
    .dbg_acc      (dbg_acc)
  );

  // R10: a disabled unit is running with clear flags on the next cycle
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |=> (!halted && hit_flags == '0));

endmodule

// File: tb/test_dbg_brk_ctl.sv
module test_dbg_brk_ctl;

  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_en = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = 2'd0;
  logic [36:0] cfg_wdata = '0;
  logic        flag_clr_we = 1'b0;
  logic [3:0]  flag_clr = 4'd0;
  logic [3:0]  hit_flags;
  logic        host_mem_req = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_space = 2'd0;
  logic [15:0] acc_addr = 16'd0;
  logic [7:0]  acc_data = 8'd0;
  logic        cpu_busy = 1'b0;
  logic        instr_done = 1'b0;
  logic        exec_en, skip_req, halted, code_run, dbg_acc;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  int n_start = 0;
  int cpu_cnt = 0;
  int cpu_len = 2;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  dbg_brk_ctl i_dbg_brk_ctl (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .flag_clr_we(flag_clr_we), .flag_clr(flag_clr), .hit_flags(hit_flags),
    .host_mem_req(host_mem_req), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_data(acc_data),
    .cpu_busy(cpu_busy), .instr_done(instr_done), .exec_en(exec_en),
    .skip_req(skip_req), .halted(halted), .code_run(code_run), .dbg_acc(dbg_acc)
  );

  // ---------------- reference model (0 run, 1 pending, 2 halted, 3 step, 4 skip)
  int       m_state;
  bit [3:0] m_flags;
  bit       m_dacc;
  bit       m_en[NB], m_rd[NB], m_wr[NB];
  int       m_space[NB], m_addr[NB], m_pat[NB], m_mask[NB];

  always @(posedge clk or negedge rst_n) begin
    bit [3:0] h;
    int       ns;
    bit       dir;
    if (!rst_n) begin
      m_state = 0; m_flags = 0; m_dacc = 0;
      for (int i = 0; i < NB; i++) begin
        m_en[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
        m_space[i] = 0; m_addr[i] = 0; m_pat[i] = 0; m_mask[i] = 0;
      end
    end else begin
      h = 0;
      for (int i = 0; i < NB; i++) begin
        dir = acc_write ? m_wr[i] : m_rd[i];
        if (dbg_en && acc_valid && m_en[i] && dir && (int'(acc_space) == m_space[i]) &&
            (int'(acc_addr) == m_addr[i]) && (((int'(acc_data) ^ m_pat[i]) & m_mask[i]) == 0))
          h[i] = 1;
      end
      ns = m_state;
      if (!dbg_en) ns = 0;
      else if (m_state == 0) begin
        if (h != 0 || (cmd_valid && cmd_op == 3'd1)) ns = 1;
      end else if (m_state == 1) begin
        if (instr_done || !cpu_busy) ns = 2;
      end else if (m_state == 2) begin
        if (cmd_valid && cmd_op == 3'd2) ns = 0;
        else if (cmd_valid && cmd_op == 3'd3) ns = 3;
        else if (cmd_valid && cmd_op == 3'd4) ns = 4;
      end else if (m_state == 3) begin
        if (instr_done) ns = 2;
      end else ns = 2;
      if (!dbg_en) m_flags = 0;
      else begin
        if (flag_clr_we) m_flags = m_flags & ~flag_clr;
        m_flags = m_flags | h;
      end
      m_dacc = dbg_en && host_mem_req && (m_state == 2);
      m_state = ns;
      if (cfg_we) begin
        m_mask[cfg_idx]  = int'(cfg_wdata[7:0]);
        m_pat[cfg_idx]   = int'(cfg_wdata[15:8]);
        m_addr[cfg_idx]  = int'(cfg_wdata[31:16]);
        m_space[cfg_idx] = int'(cfg_wdata[33:32]);
        m_wr[cfg_idx]    = cfg_wdata[34];
        m_rd[cfg_idx]    = cfg_wdata[35];
        m_en[cfg_idx]    = cfg_wdata[36];
      end
    end
  end

  // ---------------- CPU stand-in: instructions of 2..4 cycles, one idle cycle between
  always @(negedge clk) begin
    if (!rst_n) begin
      cpu_busy = 0; instr_done = 0;
    end else if (instr_done) begin
      cpu_busy = 0; instr_done = 0;
    end else if (cpu_busy) begin
      cpu_cnt++;
      if (cpu_cnt == cpu_len - 1) begin
        instr_done = 1; n_done++;
      end
    end else if (exec_en) begin
      cpu_busy = 1; cpu_cnt = 0; cpu_len = 2 + (n_start % 3); n_start++;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      cmp("R4 exec_en vs model", int'(exec_en), int'(m_state == 0 || m_state == 3));
      cmp("R4 halted vs model", int'(halted), int'(m_state == 2));
      cmp("R7 skip_req vs model", int'(skip_req), int'(m_state == 4));
      cmp("R8 code_run vs model", int'(code_run), int'(!(m_state == 2 || m_state == 4)));
      cmp("R9 dbg_acc vs model", int'(dbg_acc), int'(m_dacc));
      cmp("R3 hit_flags vs model", int'(hit_flags), int'(m_flags));
    end
  end

  function automatic logic [36:0] mk_cfg(bit en, bit rd, bit wr, int sp, int ad, int pt, int mk);
    return {en, rd, wr, 2'(sp), 16'(ad), 8'(pt), 8'(mk)};
  endfunction

  task automatic step_clk();
    @(negedge clk); #1;
  endtask

  task automatic write_cfg(input int idx, input logic [36:0] w);
    step_clk();
    cfg_we = 1; cfg_idx = 2'(idx); cfg_wdata = w;
    step_clk();
    cfg_we = 0;
  endtask

  task automatic access(input int sp, input bit wr, input int ad, input int dt);
    step_clk();
    acc_valid = 1; acc_space = 2'(sp); acc_write = wr; acc_addr = 16'(ad); acc_data = 8'(dt);
    step_clk();
    acc_valid = 0;
  endtask

  task automatic command(input int op);
    step_clk();
    cmd_valid = 1; cmd_op = 3'(op);
    step_clk();
    cmd_valid = 0;
  endtask

  task automatic clear_flags(input int m);
    step_clk();
    flag_clr_we = 1; flag_clr = 4'(m);
    step_clk();
    flag_clr_we = 0;
  endtask

  task automatic mem_req();
    step_clk();
    host_mem_req = 1;
    step_clk();
    host_mem_req = 0;
  endtask

  task automatic wait_halted();
    for (int k = 0; k < 200; k++) begin
      if (halted) break;
      step_clk();
    end
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step_clk();
    // R11 reset state
    cmp("R11 exec_en after reset", int'(exec_en), 1);
    cmp("R11 code_run after reset", int'(code_run), 1);
    cmp("R11 halted after reset", int'(halted), 0);
    cmp("R11 skip_req after reset", int'(skip_req), 0);
    cmp("R11 dbg_acc after reset", int'(dbg_acc), 0);
    cmp("R11 hit_flags after reset", int'(hit_flags), 0);
    cmp_on = 1;
    dbg_en = 1;

    // R1 address, space and direction qualification
    write_cfg(0, mk_cfg(1, 1, 0, 1, 16'h0030, 0, 0));
    write_cfg(2, mk_cfg(1, 0, 0, 0, 16'h1234, 0, 0));
    access(1, 1, 16'h0030, 0);
    cmp("R1 write to read-only bp", int'(hit_flags), 0);
    access(2, 0, 16'h0030, 0);
    cmp("R1 wrong space", int'(hit_flags), 0);
    access(1, 0, 16'h0031, 0);
    cmp("R1 wrong address", int'(hit_flags), 0);
    access(0, 0, 16'h1234, 0);
    access(0, 1, 16'h1234, 0);
    cmp("R1 both direction enables clear", int'(hit_flags), 0);
    cmp("R1 still running", int'(exec_en), 1);
    access(1, 0, 16'h0030, 8'h77);
    cmp("R3 flag set on hit", int'(hit_flags), 1);
    cmp("R4 exec_en drops after hit", int'(exec_en), 0);
    wait_halted();
    cmp("R4 halted after hit", int'(halted), 1);
    cmp("R4 cpu idle when halted", int'(cpu_busy), 0);

    // R9 debugger access while halted
    mem_req();
    cmp("R9 dbg_acc while halted", int'(dbg_acc), 1);
    step_clk();
    cmp("R9 dbg_acc one cycle", int'(dbg_acc), 0);
    command(1);
    cmp("R12 halt while halted ignored", int'(halted), 1);
    clear_flags(1);
    cmp("R3 write-one-to-clear", int'(hit_flags), 0);
    cmp("R8 code_run low when halted", int'(code_run), 0);

    // R6 single step
    d0 = n_done;
    command(3);
    cmp("R6 exec_en during step", int'(exec_en), 1);
    wait_halted();
    cmp("R6 halted after step", int'(halted), 1);
    cmp("R6 exactly one instruction", n_done - d0, 1);

    // R7 skip
    d0 = n_done;
    command(4);
    cmp("R7 skip_req raised", int'(skip_req), 1);
    cmp("R7 exec_en low in skip", int'(exec_en), 0);
    cmp("R8 code_run low in skip", int'(code_run), 0);
    step_clk();
    cmp("R7 back to halted", int'(halted), 1);
    cmp("R7 skip_req single cycle", int'(skip_req), 0);
    cmp("R7 no instruction executed", n_done - d0, 0);

    // R5 resume, R12 stray commands while running
    command(2);
    cmp("R5 exec_en after run", int'(exec_en), 1);
    cmp("R8 code_run while running", int'(code_run), 1);
    command(3);
    cmp("R12 step ignored while running", int'(exec_en), 1);
    command(4);
    cmp("R12 skip ignored while running", int'(skip_req), 0);
    mem_req();
    cmp("R9 request ignored while running", int'(dbg_acc), 0);
    d0 = n_done;
    repeat (20) step_clk();
    cmp("R5 instructions execute", int'(n_done - d0 > 3), 1);

    // R2 data pattern with mask
    write_cfg(1, mk_cfg(1, 0, 1, 3, 16'h0090, 8'hA5, 8'hF0));
    access(3, 1, 16'h0090, 8'hB5);
    cmp("R2 masked data mismatch", int'(hit_flags), 0);
    access(3, 0, 16'h0090, 8'hA3);
    cmp("R1 read on write-only bp", int'(hit_flags), 0);
    cmp("R2 still running", int'(exec_en), 1);
    access(3, 1, 16'h0090, 8'hA3);
    cmp("R2 masked data match", int'(hit_flags), 2);
    wait_halted();
    cmp("R2 halted on data hit", int'(halted), 1);
    clear_flags(2);

    // R4 halt command during an instruction
    command(2);
    for (int k = 0; k < 50; k++) begin
      if (cpu_busy && !instr_done) break;
      step_clk();
    end
    d0 = n_done;
    cmd_valid = 1; cmd_op = 3'd1;
    step_clk();
    cmd_valid = 0;
    cmp("R4 exec_en low after halt cmd", int'(exec_en), 0);
    cmp("R4 not halted mid-instruction", int'(halted), 0);
    wait_halted();
    cmp("R4 halted after halt cmd", int'(halted), 1);
    cmp("R4 in-flight instruction completed", n_done - d0, 1);

    // R3 set beats clear in the same cycle
    step_clk();
    acc_valid = 1; acc_space = 2'd3; acc_write = 1; acc_addr = 16'h0090; acc_data = 8'hA0;
    flag_clr_we = 1; flag_clr = 4'd2;
    step_clk();
    acc_valid = 0; flag_clr_we = 0;
    cmp("R3 set wins over clear", int'(hit_flags), 2);

    // R10 disabled unit
    dbg_en = 0;
    step_clk();
    cmp("R10 flags cleared when disabled", int'(hit_flags), 0);
    cmp("R10 running when disabled", int'(exec_en), 1);
    access(1, 0, 16'h0030, 0);
    cmp("R10 no hit when disabled", int'(hit_flags), 0);
    command(1);
    cmp("R10 halt ignored when disabled", int'(halted), 0);
    cmp("R10 exec_en kept when disabled", int'(exec_en), 1);
    mem_req();
    cmp("R10 no debugger access when disabled", int'(dbg_acc), 0);
    dbg_en = 1;
    repeat (10) step_clk();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule